// File: doc/BRIEF.md
# Timer Compare/Capture Unit

This unit sits beside a free-running up-counter and serves one channel of a timer. In compare mode it checks the selected counter value against two compare values, A and B, on every clock. Each match raises a flag, and the matches drive two waveform outputs. Each output has its own waveform mode and polarity, so it can act as a PWM output or a divided clock. In capture mode the same channel watches two trigger inputs. A selected edge on a trigger copies the counter into that trigger's capture register. The two modes never run at the same time.

The compare values, waveform controls, edge selections and interrupt enables come in as plain inputs; the register interface that would hold them is outside the unit. A select input lets the unit read a neighbouring channel's counter instead of its own. One counter can then feed both this unit and its own channel's unit, giving four compare or capture paths. Four sticky event flags feed a single interrupt request through per-flag enables. Each capture path also tracks whether its last value was read and raises an overrun flag when a newer capture replaces an unread one.

Top module: `tcc_unit`

## Requirements
- R1: `mode_i` = 0 selects compare mode and 1 selects capture mode. Compare matches set flags and move the outputs only in compare mode. Trigger edges load capture registers only in capture mode.
- R2: In compare mode, if the selected counter equals `cmp_a_i` at a clock edge, flag bit 0 is set at that edge. If it equals `cmp_b_i`, flag bit 1 is set at that edge. The match is tested on every clock while the values are equal.
- R3: The 2-bit control of each output sets its waveform mode. 00 holds the output low. 01 sets it on a compare-A match and clears it on a compare-B match; when both match at once, the clear wins. 10 toggles it on each compare-A match. 11 toggles it on each compare-B match. The output changes at the same edge that sets the matching flag.
- R4: The invert input of each output flips that output's level at once, without a clock.
- R5: A capture trigger is synchronized by two flops. If the trigger changes between clock edges, the capture register is loaded on the third rising edge after the change, together with flag bit 2 (trigger A) or bit 3 (trigger B). The register takes the counter value present at that edge.
- R6: Each trigger has a 2-bit edge select: 00 captures nothing, 01 captures on a rising edge, 10 on a falling edge and 11 on both edges.
- R7: A flag stays set until a 1 is written to its bit of `flag_clr_i`. A set event in the same cycle as the clear keeps the flag set.
- R8: `irq_o` is high exactly when some flag is set and its bit in `irq_en_i` is 1. It responds to a change of the enables without a clock.
- R9: A capture on a path whose previous value has not yet been read sets that path's overrun bit (bit 0 for A, bit 1 for B). The register still takes the new value.
- R10: `cnt_sel_i` = 0 takes the counter from `cnt_own_i` and 1 takes it from `cnt_alt_i`, for both comparing and capturing.
- R11: A change of `mode_i` clears all flags, overrun bits and unread marks at the next edge. It also returns both outputs to their idle level, which is low, or high when that output is inverted.
- R12: A pulse on a path's read strobe marks its value as read, so the next capture does not overrun. Writing 1 to that path's capture flag bit also clears its overrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_own_i | input | CNT_W | Counter of this channel |
| cnt_alt_i | input | CNT_W | Counter of the neighbouring channel |
| cnt_sel_i | input | 1 | Counter source select |
| mode_i | input | 1 | 0 compare, 1 capture |
| cmp_a_i | input | CNT_W | Compare value A |
| cmp_b_i | input | CNT_W | Compare value B |
| wave_a_ctl_i | input | 2 | Waveform mode of output A |
| wave_b_ctl_i | input | 2 | Waveform mode of output B |
| wave_a_inv_i | input | 1 | Invert output A |
| wave_b_inv_i | input | 1 | Invert output B |
| trig_a_i | input | 1 | Capture trigger A, asynchronous |
| trig_b_i | input | 1 | Capture trigger B, asynchronous |
| edge_a_sel_i | input | 2 | Edge select of trigger A |
| edge_b_sel_i | input | 2 | Edge select of trigger B |
| cap_a_rd_i | input | 1 | Capture A has been read |
| cap_b_rd_i | input | 1 | Capture B has been read |
| irq_en_i | input | 4 | Interrupt enable per flag |
| flag_clr_i | input | 4 | Write-one-to-clear per flag |
| wave_a_o | output | 1 | Waveform output A |
| wave_b_o | output | 1 | Waveform output B |
| cap_a_o | output | CNT_W | Capture register A |
| cap_b_o | output | CNT_W | Capture register B |
| flags_o | output | 4 | Event flags: cmp A, cmp B, cap A, cap B |
| ovr_o | output | 2 | Overrun bits: A, B |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench forces a compare-A and compare-B match in the same cycle on a PWM output. A design that gave set priority would leave the output high. It repeats a match for several cycles in the toggle modes, where a design that only reacted to the first equal cycle would stop toggling. It checks the capture flag one edge before the expected capture edge, so a synchronizer that is one flop short or long is reported. It then presents the edge an edge select should reject, where a design with mixed-up edge encodings would capture. The overrun tests capture twice without a read and then once after a read, to catch a missing overrun or a read strobe that does nothing. The clear-and-set collision, the alternate counter and the mode switch check that flags are not lost, that the counter source is really switched and that a mode switch leaves nothing pending.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        WAVE_OFF   = 2'b00,
        WAVE_PWM   = 2'b01,
        WAVE_TGL_A = 2'b10,
        WAVE_TGL_B = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        MODE_CMP = 1'b0,
        MODE_CAP = 1'b1
    } unit_mode_e;

    localparam int unsigned NUM_PATHS = 2;
    localparam int unsigned NUM_EVT   = 2 * NUM_PATHS;

endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync
    import tcc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] sel_i,
    output logic       pulse_o
);

    localparam int unsigned TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], pin_i};
        st_d.last  = st_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.chain[TOP] & ~st_q.last;
    assign fall = ~st_q.chain[TOP] & st_q.last;

    always_comb begin
        unique case (edge_sel_e'(sel_i))
            EDGE_NONE: pulse_o = 1'b0;
            EDGE_RISE: pulse_o = rise;
            EDGE_FALL: pulse_o = fall;
            EDGE_BOTH: pulse_o = rise | fall;
            default:   pulse_o = 1'b0;
        endcase
    end

    AST_NO_EDGE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b00) |-> !pulse_o); // R6

endmodule

// File: rtl/tcc_wave.sv
module tcc_wave
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       run_i,
    input  logic [1:0] ctl_i,
    input  logic       inv_i,
    input  logic       hit_a_i,
    input  logic       hit_b_i,
    output logic       wave_o
);

    typedef struct packed {
        logic raw;
    } wave_state_t;

    wave_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i || !run_i) begin
            st_d.raw = 1'b0;
        end else begin
            unique case (wave_mode_e'(ctl_i))
                WAVE_OFF:   st_d.raw = 1'b0;
                WAVE_PWM: begin
                    if (hit_b_i)      st_d.raw = 1'b0;
                    else if (hit_a_i) st_d.raw = 1'b1;
                end
                WAVE_TGL_A: if (hit_a_i) st_d.raw = ~st_q.raw;
                WAVE_TGL_B: if (hit_b_i) st_d.raw = ~st_q.raw;
                default:    st_d.raw = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wave_o = st_q.raw ^ inv_i;

    AST_OFF_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i == 2'b00) |=> (wave_o == inv_i)); // R3
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (wave_o == inv_i)); // R11
    AST_PWM_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && ctl_i == 2'b01 && hit_b_i) |=> (wave_o == inv_i)); // R3

endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
    import tcc_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_own_i,
    input  logic [CNT_W-1:0] cnt_alt_i,
    input  logic             cnt_sel_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  logic [1:0]       wave_a_ctl_i,
    input  logic [1:0]       wave_b_ctl_i,
    input  logic             wave_a_inv_i,
    input  logic             wave_b_inv_i,
    input  logic             trig_a_i,
    input  logic             trig_b_i,
    input  logic [1:0]       edge_a_sel_i,
    input  logic [1:0]       edge_b_sel_i,
    input  logic             cap_a_rd_i,
    input  logic             cap_b_rd_i,
    input  logic [3:0]       irq_en_i,
    input  logic [3:0]       flag_clr_i,
    output logic             wave_a_o,
    output logic             wave_b_o,
    output logic [CNT_W-1:0] cap_a_o,
    output logic [CNT_W-1:0] cap_b_o,
    output logic [3:0]       flags_o,
    output logic [1:0]       ovr_o,
    output logic             irq_o
);

    localparam int unsigned CAP_FLAG0 = NUM_PATHS;

    typedef struct packed {
        unit_mode_e                            mode;
        logic [NUM_EVT-1:0]                    flags;
        logic [NUM_PATHS-1:0]                  ovr;
        logic [NUM_PATHS-1:0]                  unread;
        logic [NUM_PATHS-1:0][CNT_W-1:0]       cap;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [CNT_W-1:0]     cnt;
    logic                 mode_chg;
    logic                 cmp_live;
    logic                 cap_live;
    logic                 hit_a, hit_b;
    logic [NUM_PATHS-1:0] trig;
    logic [NUM_PATHS-1:0] rd;
    logic [NUM_PATHS-1:0][1:0] esel;
    logic [NUM_PATHS-1:0] edge_pulse;
    logic [NUM_PATHS-1:0] cap_evt;
    logic [NUM_EVT-1:0]   events;

    assign cnt      = cnt_sel_i ? cnt_alt_i : cnt_own_i;
    assign mode_chg = (unit_mode_e'(mode_i) != st_q.mode);
    assign cmp_live = (st_q.mode == MODE_CMP) && !mode_chg;
    assign cap_live = (st_q.mode == MODE_CAP) && !mode_chg;
    assign hit_a    = cmp_live && (cnt == cmp_a_i);
    assign hit_b    = cmp_live && (cnt == cmp_b_i);

    assign trig = {trig_b_i, trig_a_i};
    assign rd   = {cap_b_rd_i, cap_a_rd_i};
    assign esel = {edge_b_sel_i, edge_a_sel_i};

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PATHS; gp++) begin : g_path
            tcc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_i   (trig[gp]),
                .sel_i   (esel[gp]),
                .pulse_o (edge_pulse[gp])
            );
            assign cap_evt[gp] = cap_live & edge_pulse[gp];
        end
    endgenerate

    assign events = {cap_evt, hit_b, hit_a};

    tcc_wave u_wave_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (mode_chg),
        .run_i   (cmp_live),
        .ctl_i   (wave_a_ctl_i),
        .inv_i   (wave_a_inv_i),
        .hit_a_i (hit_a),
        .hit_b_i (hit_b),
        .wave_o  (wave_a_o)
    );

    tcc_wave u_wave_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (mode_chg),
        .run_i   (cmp_live),
        .ctl_i   (wave_b_ctl_i),
        .inv_i   (wave_b_inv_i),
        .hit_a_i (hit_a),
        .hit_b_i (hit_b),
        .wave_o  (wave_b_o)
    );

    always_comb begin
        st_d = st_q;
        if (mode_chg) begin
            st_d.mode   = unit_mode_e'(mode_i);
            st_d.flags  = '0;
            st_d.ovr    = '0;
            st_d.unread = '0;
        end else begin
            st_d.flags = (st_q.flags & ~flag_clr_i) | events;
            for (int p = 0; p < NUM_PATHS; p++) begin
                if (cap_evt[p]) begin
                    st_d.cap[p]    = cnt;
                    st_d.unread[p] = 1'b1;
                end else if (rd[p]) begin
                    st_d.unread[p] = 1'b0;
                end
                if (cap_evt[p] && st_q.unread[p] && !rd[p]) begin
                    st_d.ovr[p] = 1'b1;
                end else if (flag_clr_i[CAP_FLAG0 + p]) begin
                    st_d.ovr[p] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_CMP, default: '0};
        else        st_q <= st_d;
    end

    assign cap_a_o = st_q.cap[0];
    assign cap_b_o = st_q.cap[1];
    assign flags_o = st_q.flags;
    assign ovr_o   = st_q.ovr;
    assign irq_o   = |(st_q.flags & irq_en_i);

    AST_CAP_MODE_NO_CMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_CAP) |-> (st_q.flags[1:0] == 2'b00)); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chg |=> ((($past(st_q.flags) & ~$past(flag_clr_i)) & ~st_q.flags) == '0)); // R7
    AST_MODE_SWITCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (st_q.flags == '0 && st_q.ovr == '0)); // R11
    AST_CAP_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt[0] |=> $stable(cap_a_o)); // R5
    AST_CAP_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt[1] |=> $stable(cap_b_o)); // R5
    AST_OVR_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o[0]) |-> $past(cap_evt[0])); // R9
    AST_OVR_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o[1]) |-> $past(cap_evt[1])); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i == 4'b0000) |-> !irq_o); // R8

endmodule

// File: tb/tcc_unit_tb_top.sv
module tcc_unit_tb_top;

    localparam int unsigned CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_own = '0, cnt_alt = '0;
    logic             cnt_sel = 1'b0, mode = 1'b0;
    logic [CNT_W-1:0] cmp_a = 16'd5, cmp_b = 16'd9;
    logic [1:0]       ctl_a = 2'b01, ctl_b = 2'b11;
    logic             inv_a = 1'b0, inv_b = 1'b0;
    logic             trig_a = 1'b0, trig_b = 1'b0;
    logic [1:0]       esel_a = 2'b00, esel_b = 2'b00;
    logic             rd_a = 1'b0, rd_b = 1'b0;
    logic [3:0]       irq_en = 4'b0000, flag_clr = 4'b0000;
    logic             wave_a, wave_b, irq;
    logic [CNT_W-1:0] cap_a, cap_b;
    logic [3:0]       flags;
    logic [1:0]       ovr;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    tcc_unit #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cnt_own_i(cnt_own), .cnt_alt_i(cnt_alt), .cnt_sel_i(cnt_sel),
        .mode_i(mode), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
        .wave_a_ctl_i(ctl_a), .wave_b_ctl_i(ctl_b),
        .wave_a_inv_i(inv_a), .wave_b_inv_i(inv_b),
        .trig_a_i(trig_a), .trig_b_i(trig_b),
        .edge_a_sel_i(esel_a), .edge_b_sel_i(esel_b),
        .cap_a_rd_i(rd_a), .cap_b_rd_i(rd_b),
        .irq_en_i(irq_en), .flag_clr_i(flag_clr),
        .wave_a_o(wave_a), .wave_b_o(wave_b),
        .cap_a_o(cap_a), .cap_b_o(cap_b),
        .flags_o(flags), .ovr_o(ovr), .irq_o(irq)
    );

    // {counter, expected wave A, expected wave B}; A in PWM (set 5, clear 9), B toggles on 9
    localparam logic [17:0] VEC [8] = '{
        {16'd3, 1'b0, 1'b0},
        {16'd5, 1'b1, 1'b0},
        {16'd7, 1'b1, 1'b0},
        {16'd9, 1'b0, 1'b1},
        {16'd5, 1'b1, 1'b1},
        {16'd9, 1'b0, 1'b0},
        {16'd9, 1'b0, 1'b1},
        {16'd0, 1'b0, 1'b1}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        steps(3);
        rst_n = 1'b1;
        step();
        // reset state
        chk("R3", "reset wave A", {31'd0, wave_a}, 0);
        chk("R3", "reset wave B", {31'd0, wave_b}, 0);
        chk("R7", "reset flags", {28'd0, flags}, 0);
        chk("R8", "reset irq", {31'd0, irq}, 0);

        // table walk: compare mode, PWM on A and toggle-on-B on B
        for (int v = 0; v < 8; v++) begin
            cnt_own = VEC[v][17:2];
            step();
            chk("R3", $sformatf("vec %0d wave A", v), {31'd0, wave_a}, {31'd0, VEC[v][1]});
            chk("R3", $sformatf("vec %0d wave B", v), {31'd0, wave_b}, {31'd0, VEC[v][0]});
        end
        chk("R2", "both compare flags", {28'd0, flags}, 4'b0011);

        // interrupt masking R8
        chk("R8", "irq masked", {31'd0, irq}, 0);
        irq_en = 4'b0001; #1;
        chk("R8", "irq enabled", {31'd0, irq}, 1);
        flag_clr = 4'b0001; step(); flag_clr = 4'b0000;
        chk("R7", "w1c bit0", {28'd0, flags}, 4'b0010);
        #1 chk("R8", "irq after clear", {31'd0, irq}, 0);
        irq_en = 4'b0010; #1;
        chk("R8", "irq bit1", {31'd0, irq}, 1);
        irq_en = 4'b0000;

        // set wins over clear R7
        cnt_own = 16'd5; step();
        flag_clr = 4'b0001; step();
        chk("R7", "set beats clear", {28'd0, flags}, 4'b0011);
        cnt_own = 16'd0; step(); flag_clr = 4'b0000;
        chk("R7", "clear alone", {28'd0, flags}, 4'b0010);

        // invert R4 (raw A is high after the match at 5)
        inv_a = 1'b1; #1;
        chk("R4", "inverted A", {31'd0, wave_a}, 0);
        inv_a = 1'b0; #1;
        chk("R4", "uninverted A", {31'd0, wave_a}, 1);

        // tie: A and B match together, clear wins R3
        cmp_a = 16'd4; cmp_b = 16'd4; cnt_own = 16'd4; step();
        chk("R3", "PWM tie clears", {31'd0, wave_a}, 0);

        // toggle on A for output B R3
        cmp_b = 16'd6; ctl_b = 2'b10; cnt_own = 16'd0; step();
        chk("R3", "B before toggle", {31'd0, wave_b}, 0);
        cnt_own = 16'd4; step();
        chk("R3", "B toggles on A", {31'd0, wave_b}, 1);
        step();
        chk("R3", "B toggles again", {31'd0, wave_b}, 0);
        cnt_own = 16'd6; step();
        chk("R3", "B ignores B match", {31'd0, wave_b}, 0);

        // off mode R3
        cnt_own = 16'd4; step();
        chk("R3", "A set by PWM", {31'd0, wave_a}, 1);
        ctl_a = 2'b00; cnt_own = 16'd0; step();
        chk("R3", "off mode low", {31'd0, wave_a}, 0);

        // counter select R10
        flag_clr = 4'b1111; step(); flag_clr = 4'b0000;
        cnt_sel = 1'b1; cnt_alt = 16'd6; cnt_own = 16'd4; step();
        chk("R10", "alt counter match", {28'd0, flags}, 4'b0010);
        cnt_sel = 1'b0; step();
        chk("R10", "own counter match", {28'd0, flags}, 4'b0011);

        // mode change R11
        inv_a = 1'b1; mode = 1'b1; step();
        chk("R11", "flags cleared", {28'd0, flags}, 0);
        chk("R11", "A idles at inverted level", {31'd0, wave_a}, 1);
        chk("R11", "B idles low", {31'd0, wave_b}, 0);
        inv_a = 1'b0; step();
        chk("R1", "no compare flags in capture", {28'd0, flags}, 0);

        // rising capture on A, timing R5
        esel_a = 2'b01; cnt_own = 16'd100; step();
        trig_a = 1'b1; steps(2);
        chk("R5", "no capture after two edges", {28'd0, flags}, 0);
        step();
        chk("R5", "capture flag on third edge", {28'd0, flags}, 4'b0100);
        chk("R5", "capture A value", {16'd0, cap_a}, 100);

        // falling edge ignored with rising select R6
        cnt_own = 16'd200; trig_a = 1'b0; steps(4);
        chk("R6", "rise select ignores fall", {16'd0, cap_a}, 100);

        // both edges on B, overrun R9
        esel_b = 2'b11; cnt_own = 16'd300; trig_b = 1'b1; steps(3);
        chk("R6", "both select rise", {16'd0, cap_b}, 300);
        chk("R9", "no overrun yet", {30'd0, ovr}, 0);
        cnt_own = 16'd400; trig_b = 1'b0; steps(3);
        chk("R6", "both select fall", {16'd0, cap_b}, 400);
        chk("R9", "overrun on B", {30'd0, ovr}, 2'b10);

        // read and clear R12
        rd_b = 1'b1; step(); rd_b = 1'b0;
        flag_clr = 4'b1000; step(); flag_clr = 4'b0000;
        chk("R12", "overrun cleared", {30'd0, ovr}, 0);
        chk("R12", "cap B flag cleared", {28'd0, flags}, 4'b0100);
        cnt_own = 16'd500; trig_b = 1'b1; steps(3);
        chk("R12", "capture after read", {16'd0, cap_b}, 500);
        chk("R12", "no overrun after read", {30'd0, ovr}, 0);

        // falling select on A R6
        rd_a = 1'b1; step(); rd_a = 1'b0;
        esel_a = 2'b10; cnt_own = 16'd550; trig_a = 1'b1; steps(3);
        chk("R6", "fall select ignores rise", {16'd0, cap_a}, 100);
        cnt_own = 16'd600; trig_a = 1'b0; steps(3);
        chk("R6", "fall select captures", {16'd0, cap_a}, 600);
        chk("R9", "A read before, no overrun", {30'd0, ovr}, 0);

        // no-edge select R6
        esel_a = 2'b00; cnt_own = 16'd700; trig_a = 1'b1; steps(4);
        chk("R6", "none select", {16'd0, cap_a}, 600);

        // back to compare mode R11, then triggers ignored R1
        mode = 1'b0; step();
        chk("R11", "flags cleared on return", {28'd0, flags}, 0);
        chk("R11", "overrun cleared on return", {30'd0, ovr}, 0);
        esel_a = 2'b11; cnt_own = 16'd800; trig_a = 1'b0; steps(4);
        chk("R1", "no capture in compare mode", {16'd0, cap_a}, 600);
        chk("R1", "no capture flag in compare mode", {31'd0, flags[2]}, 0);

        finish_run();
    end

endmodule